// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block sits between an instruction memory port and an execution unit. It reads 16-bit words one at a time at the address held in its instruction counter. For each instruction it emits one decoded record: the mode flag, a 5-bit opcode, a 5-bit destination index, a tag that gives the kind of source operand, and the resolved 16-bit operand value.

A first word is laid out with the mode flag in bit 15, the opcode in bits 14:10, the destination in bits 9:5 and the source field in bits 4:0. When the mode flag is 0 and the source field is all ones, the instruction is two words long. In that case the decoder fetches the next word as a 16-bit immediate and issues only after it has that word. Every other first word is a complete instruction.

The memory port is assumed to answer in the same cycle: `memWord` belongs to `fetchAddr` whenever `memValid` is high. A stall input freezes the block. A counter-load input redirects fetch for jumps and drops any instruction that is only partly collected.

Top module: `instr_fetch_decoder`

## Requirements
- R1: After reset, `fetchAddr` is 0, `decValid` is 0, and the next accepted word is treated as a first word.
- R2: A first word with mode 0 and a source field other than 31 is a one-word instruction. One cycle after it is accepted, `decValid` is 1, `decKind` is 0 (register), and `decOperand` is the source field zero-extended. The opcode and destination are copied unchanged, and `decAddr` is the word's address.
- R3: A first word with mode 1 is a one-word instruction for every source value, including 31. Its `decKind` is 1 (literal), `decOperand` is the 5-bit field zero-extended, and `decMode` is 1.
- R4: A first word with mode 0 and source 31 issues nothing on its own. One cycle after the following word is accepted, `decValid` is 1, `decKind` is 2 (immediate), and `decOperand` is that whole word. Opcode, destination and `decAddr` come from the first word.
- R5: `fetchAddr` advances by exactly one for each accepted word and wraps from the highest address to 0. A word is accepted when `memValid` is 1 and both `stall` and `loadEn` are 0.
- R6: While `memValid` is 0, no word is consumed, `fetchAddr` and the fetch state are kept, and `decValid` drops to 0 on the next cycle.
- R7: While `stall` is 1 (without `loadEn`), `fetchAddr`, the fetch state and every decode output, `decValid` included, hold their values, and `memWord` is ignored.
- R8: When `loadEn` is 1, `fetchAddr` becomes `loadAddr` on the next cycle, `decValid` becomes 0, and any half-fetched two-word instruction is discarded. This happens even if `stall` or `memValid` is also 1.
- R9: `decValid` is high for exactly one cycle per issued instruction, unless the block is stalled or another instruction issues on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fetchAddr | output | 20 | Instruction counter; address of the word being requested |
| memWord | input | 16 | Word read from instruction memory at `fetchAddr` |
| memValid | input | 1 | `memWord` is valid this cycle |
| stall | input | 1 | Freeze state, counter and outputs |
| loadEn | input | 1 | Load the counter from `loadAddr`; drop any partial instruction |
| loadAddr | input | 20 | New counter value for jumps |
| decValid | output | 1 | A decoded instruction is presented |
| decMode | output | 1 | Mode flag of the instruction |
| decOpcode | output | 5 | Opcode field, copied unchanged |
| decDest | output | 5 | Destination register index |
| decKind | output | 2 | Source kind: 0 register, 1 literal, 2 immediate |
| decOperand | output | 16 | Register index, literal, or immediate value |
| decAddr | output | 20 | Address of the instruction's first word |

## Verification
The case that matters most is a counter load in the same cycle that the immediate word of a two-word instruction is offered. The bench holds a pending long instruction, then raises `loadEn` while presenting a valid word. It expects the counter to take the new address, no instruction to issue, and the next word to decode as a fresh first word at the loaded address. The bench also asserts `stall` and `loadEn` together right after an issue, and expects the load to win and `decValid` to clear rather than hold.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  localparam int WORD_W   = 16;
  localparam int FIELD_W  = 5;
  localparam int MODE_BIT = WORD_W - 1;
  localparam int OPC_LO   = MODE_BIT - FIELD_W;
  localparam int DST_LO   = OPC_LO - FIELD_W;
  localparam int SRC_LO   = DST_LO - FIELD_W;

  typedef enum logic [1:0] {
    KIND_REG = 2'd0,
    KIND_LIT = 2'd1,
    KIND_IMM = 2'd2
  } srcKindT;

  typedef enum logic {
    FIRST_WORD = 1'b0,
    IMM_WORD   = 1'b1
  } fetchStateT;

  typedef struct packed {
    logic loadPc;
    logic hold;
    logic advancePc;
    logic captureHead;
    logic issueShort;
    logic issueLong;
  } ctrlStrobesT;
endpackage

// File: rtl/ifd_ctrl.sv
module ifd_ctrl
  import ifd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        memValid,
  input  logic        stall,
  input  logic        loadEn,
  input  logic        wordIsLong,
  output ctrlStrobesT strobes
);
  fetchStateT state;
  fetchStateT stateNext;
  logic       takeWord;

  assign takeWord = memValid & ~stall & ~loadEn;

  always_comb begin
    strobes             = '0;
    strobes.loadPc      = loadEn;
    strobes.hold        = stall & ~loadEn;
    strobes.advancePc   = takeWord;
    strobes.captureHead = takeWord & (state == FIRST_WORD) & wordIsLong;
    strobes.issueShort  = takeWord & (state == FIRST_WORD) & ~wordIsLong;
    strobes.issueLong   = takeWord & (state == IMM_WORD);
  end

  always_comb begin
    stateNext = state;
    if (loadEn)                    stateNext = FIRST_WORD;
    else if (strobes.captureHead)  stateNext = IMM_WORD;
    else if (strobes.issueLong)    stateNext = FIRST_WORD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= FIRST_WORD;
    else       state <= stateNext;
  end

  // R4: after the immediate word is taken, the controller is back on first words
  a_r4_back_to_first: assert property (@(posedge clk) disable iff (!rstN)
    (state == IMM_WORD && takeWord) |=> state == FIRST_WORD);

  // R8: a counter load always leaves the controller expecting a first word
  a_r8_load_resets_state: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> state == FIRST_WORD);

  // R7: stall without load keeps the fetch state
  a_r7_state_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !loadEn) |=> $stable(state));

  // R2: at most one word-handling action per cycle
  a_r2_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.captureHead, strobes.issueShort, strobes.issueLong}));
endmodule

// File: rtl/ifd_datapath.sv
module ifd_datapath
  import ifd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobesT           strobes,
  input  logic [WORD_W-1:0]     memWord,
  input  logic [ADDR_W-1:0]     loadAddr,
  output logic                  wordIsLong,
  output logic [ADDR_W-1:0]     ic,
  output logic                  decValid,
  output logic                  decMode,
  output logic [FIELD_W-1:0]    decOpcode,
  output logic [FIELD_W-1:0]    decDest,
  output srcKindT               decKind,
  output logic [WORD_W-1:0]     decOperand,
  output logic [ADDR_W-1:0]     decAddr
);
  localparam int PAD_W = WORD_W - FIELD_W;

  logic                 wordMode;
  logic [FIELD_W-1:0]   wordOpc;
  logic [FIELD_W-1:0]   wordDst;
  logic [FIELD_W-1:0]   wordSrc;
  logic [FIELD_W-1:0]   headOpcode;
  logic [FIELD_W-1:0]   headDest;
  logic [ADDR_W-1:0]    headAddr;

  assign wordMode   = memWord[MODE_BIT];
  assign wordOpc    = memWord[OPC_LO +: FIELD_W];
  assign wordDst    = memWord[DST_LO +: FIELD_W];
  assign wordSrc    = memWord[SRC_LO +: FIELD_W];
  assign wordIsLong = ~wordMode & (&wordSrc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ic         <= '0;
      decValid   <= 1'b0;
      decMode    <= 1'b0;
      decOpcode  <= '0;
      decDest    <= '0;
      decKind    <= KIND_REG;
      decOperand <= '0;
      decAddr    <= '0;
      headOpcode <= '0;
      headDest   <= '0;
      headAddr   <= '0;
    end else if (strobes.loadPc) begin
      ic       <= loadAddr;
      decValid <= 1'b0;
    end else if (!strobes.hold) begin
      decValid <= strobes.issueShort | strobes.issueLong;
      if (strobes.advancePc) ic <= ic + 1'b1;
      if (strobes.captureHead) begin
        headOpcode <= wordOpc;
        headDest   <= wordDst;
        headAddr   <= ic;
      end
      if (strobes.issueShort) begin
        decMode    <= wordMode;
        decOpcode  <= wordOpc;
        decDest    <= wordDst;
        decKind    <= wordMode ? KIND_LIT : KIND_REG;
        decOperand <= {{PAD_W{1'b0}}, wordSrc};
        decAddr    <= ic;
      end
      if (strobes.issueLong) begin
        decMode    <= 1'b0;
        decOpcode  <= headOpcode;
        decDest    <= headDest;
        decKind    <= KIND_IMM;
        decOperand <= memWord;
        decAddr    <= headAddr;
      end
    end
  end

  // R5: one step per accepted word, modulo the address space
  a_r5_counter_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advancePc && !strobes.loadPc) |=> ic == ADDR_W'($past(ic) + 1'b1));

  // R8: load takes the jump target
  a_r8_load_target: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadPc |=> (ic == $past(loadAddr)) && !decValid);

  // R7: stall freezes counter and outputs
  a_r7_hold_outputs: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hold |=> $stable(ic) && $stable(decValid) && $stable(decOperand) && $stable(decKind));

  // R6: nothing offered and nothing held means the counter stays and valid drops
  a_r6_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advancePc && !strobes.hold && !strobes.loadPc) |=> $stable(ic) && !decValid);
endmodule

// File: rtl/instr_fetch_decoder.sv
module instr_fetch_decoder
  import ifd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic               clk,
  input  logic               rstN,
  output logic [ADDR_W-1:0]  fetchAddr,
  input  logic [15:0]        memWord,
  input  logic               memValid,
  input  logic               stall,
  input  logic               loadEn,
  input  logic [ADDR_W-1:0]  loadAddr,
  output logic               decValid,
  output logic               decMode,
  output logic [4:0]         decOpcode,
  output logic [4:0]         decDest,
  output logic [1:0]         decKind,
  output logic [15:0]        decOperand,
  output logic [ADDR_W-1:0]  decAddr
);
  ctrlStrobesT strobes;
  logic        wordIsLong;
  srcKindT     kindInt;

  ifd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .memValid   (memValid),
    .stall      (stall),
    .loadEn     (loadEn),
    .wordIsLong (wordIsLong),
    .strobes    (strobes)
  );

  ifd_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .memWord    (memWord),
    .loadAddr   (loadAddr),
    .wordIsLong (wordIsLong),
    .ic         (fetchAddr),
    .decValid   (decValid),
    .decMode    (decMode),
    .decOpcode  (decOpcode),
    .decDest    (decDest),
    .decKind    (kindInt),
    .decOperand (decOperand),
    .decAddr    (decAddr)
  );

  assign decKind = kindInt;

  // R3: a literal-mode issue always carries the literal kind and a 5-bit operand
  a_r3_literal_kind: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && decMode) |-> (decKind == 2'd1) && (decOperand[15:5] == '0));
endmodule

// File: tb/sim_instr_fetch_decoder.sv
module sim_instr_fetch_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] fetchAddr;
  logic [15:0] memWord = '0;
  logic        memValid = 1'b0;
  logic        stall = 1'b0;
  logic        loadEn = 1'b0;
  logic [19:0] loadAddr = '0;
  logic        decValid;
  logic        decMode;
  logic [4:0]  decOpcode;
  logic [4:0]  decDest;
  logic [1:0]  decKind;
  logic [15:0] decOperand;
  logic [19:0] decAddr;

  int nChecks = 0;
  int nFail   = 0;

  always #5 clk = ~clk;

  instr_fetch_decoder u0 (.*);

  function automatic logic [15:0] mk(input logic m, input logic [4:0] op,
                                     input logic [4:0] dst, input logic [4:0] src);
    return {m, op, dst, src};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic mv, input logic [15:0] w, input logic st,
                      input logic ld, input logic [19:0] la);
    memValid = mv; memWord = w; stall = st; loadEn = ld; loadAddr = la;
    @(posedge clk); #1;
    memValid = 1'b0; stall = 1'b0; loadEn = 1'b0;
  endtask

  task automatic t_reset;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 addr", fetchAddr, 0);
    chk("R1 valid", decValid, 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1 addr after release", fetchAddr, 0);
  endtask

  task automatic t_short_reg;
    step(1, mk(0, 5'h0A, 5'd3, 5'd7), 0, 0, 0);
    chk("R2 valid", decValid, 1);
    chk("R2 kind", decKind, 0);
    chk("R2 operand", decOperand, 7);
    chk("R2 opcode", decOpcode, 5'h0A);
    chk("R2 dest", decDest, 3);
    chk("R2 addr", decAddr, 0);
    chk("R5 step", fetchAddr, 1);
    step(0, 16'hFFFF, 0, 0, 0);
    chk("R6 valid drop", decValid, 0);
    chk("R6 addr kept", fetchAddr, 1);
    chk("R9 pulse kind kept", decKind, 0);
  endtask

  task automatic t_literal;
    step(1, mk(1, 5'h15, 5'd4, 5'd31), 0, 0, 0);
    chk("R3 valid", decValid, 1);
    chk("R3 kind", decKind, 1);
    chk("R3 operand", decOperand, 16'h001F);
    chk("R3 mode", decMode, 1);
    chk("R3 addr", decAddr, 1);
    chk("R5 step", fetchAddr, 2);
  endtask

  task automatic t_long;
    step(1, mk(0, 5'd3, 5'd9, 5'd31), 0, 0, 0);
    chk("R4 no early valid", decValid, 0);
    chk("R5 step head", fetchAddr, 3);
    step(0, 16'h0, 0, 0, 0);
    chk("R4 gap valid", decValid, 0);
    chk("R6 gap addr", fetchAddr, 3);
    step(1, 16'hBEEF, 0, 0, 0);
    chk("R4 valid", decValid, 1);
    chk("R4 kind", decKind, 2);
    chk("R4 operand", decOperand, 16'hBEEF);
    chk("R4 opcode", decOpcode, 3);
    chk("R4 dest", decDest, 9);
    chk("R4 mode", decMode, 0);
    chk("R4 addr", decAddr, 2);
    chk("R5 step imm", fetchAddr, 4);
  endtask

  task automatic t_stall;
    step(1, mk(0, 5'd1, 5'd2, 5'd30), 0, 0, 0);
    chk("R2 src30 kind", decKind, 0);
    chk("R2 src30 operand", decOperand, 16'h001E);
    chk("R5 addr", fetchAddr, 5);
    step(1, mk(1, 5'd8, 5'd8, 5'd8), 1, 0, 0);
    chk("R7 valid held", decValid, 1);
    chk("R7 operand held", decOperand, 16'h001E);
    chk("R7 addr held", fetchAddr, 5);
    step(0, 0, 0, 0, 0);
    chk("R9 valid drop", decValid, 0);
    step(1, mk(0, 5'd7, 5'd1, 5'd31), 0, 0, 0);
    chk("R5 addr", fetchAddr, 6);
    step(1, 16'h1234, 1, 0, 0);
    chk("R7 no issue in stall", decValid, 0);
    chk("R7 addr held imm", fetchAddr, 6);
    step(1, 16'h5678, 0, 0, 0);
    chk("R7 imm after stall", decOperand, 16'h5678);
    chk("R4 addr after stall", decAddr, 5);
    chk("R5 addr", fetchAddr, 7);
  endtask

  task automatic t_load;
    step(1, mk(0, 5'd2, 5'd2, 5'd31), 0, 0, 0);
    chk("R5 addr", fetchAddr, 8);
    step(1, 16'hAAAA, 0, 1, 20'd100);
    chk("R8 target", fetchAddr, 100);
    chk("R8 no issue", decValid, 0);
    step(1, mk(0, 5'd4, 5'd5, 5'd6), 0, 0, 0);
    chk("R8 fresh first kind", decKind, 0);
    chk("R8 fresh operand", decOperand, 6);
    chk("R8 fresh addr", decAddr, 100);
    chk("R5 after load", fetchAddr, 101);
    step(1, mk(1, 5'd1, 5'd1, 5'd1), 0, 0, 0);
    chk("R2 issue", decValid, 1);
    step(0, 0, 1, 1, 20'd200);
    chk("R8 beats stall addr", fetchAddr, 200);
    chk("R8 beats stall valid", decValid, 0);
  endtask

  task automatic t_wrap;
    step(0, 0, 0, 1, 20'hFFFFF);
    chk("R8 load top", fetchAddr, 20'hFFFFF);
    step(1, mk(0, 5'd0, 5'd0, 5'd31), 0, 0, 0);
    chk("R5 wrap", fetchAddr, 0);
    step(1, 16'h0042, 0, 0, 0);
    chk("R4 wrap operand", decOperand, 16'h0042);
    chk("R4 wrap addr", decAddr, 20'hFFFFF);
    chk("R5 after wrap", fetchAddr, 1);
  endtask

  initial begin
    #(200000 * 10);
    nFail++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    t_short_reg();
    t_literal();
    t_long();
    t_stall();
    t_load();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule